// File: doc/BRIEF.md
# Directional Segmented Routing Switch Block

This block is the switch point of one tile in an island-style programmable fabric. Four sides (north, east, south, west) each carry `W` one-way routing tracks in and `W` out. Each outgoing track has exactly one driver, a small multiplexer. There are no tristate or bidirectional switches.

Tracks are built from segments that span `LSEG` tiles. The segment start points are staggered across the track indices. A track whose segment begins or ends at this tile is switched here. Its outgoing driver may pick the same-index incoming track from any one of the three other sides, or it may be left undriven, which gives a constant 0. A track that is in the middle of its segment normally runs straight across the tile. When the corner-turn option is built in, it may instead take the same-index track arriving on the clockwise-adjacent side.

The selects come from a shadow register. Configuration bits are shifted in serially while a load enable is high, and a commit pulse copies the whole chain into the shadow register at once. The track datapath has no registers.

Top module: `sb_switch_block`

## Requirements
- R1: After reset every segment-end outgoing track drives 0. Every mid-segment outgoing track equals the incoming track with the same index on the opposite side.
- R2: For a segment-end outgoing track `t` on side `d` (north=0, east=1, south=2, west=3), select code `k` in 1..3 drives it from incoming track `t` of side `(d+k) mod 4`. Code 0 drives it to 0.
- R3: An outgoing track with index `t` depends only on incoming tracks with index `t`.
- R4: No incoming track ever reaches an outgoing track on the side it arrived on.
- R5: For a mid-segment track, bit 0 of its field selects the path. With the bit at 0 the track runs straight from the opposite side. With the bit at 1, and the corner-turn parameter set, it is driven from side `(d+1) mod 4`. Bit 1 of a mid-segment field has no effect.
- R6: Track `t` is a segment-end track exactly when `(TILE_X + t) mod LSEG == 0`.
- R7: On each clock with `cfg_en` high, the chain shifts one bit toward its MSB and takes `cfg_din` into bit 0, so the first bit shifted in ends up as the MSB. The field for side `d`, track `t` occupies bits `(d*W+t)*SELW` upward, with `SELW = 2`. With `cfg_en` low the chain holds.
- R8: Shifting does not affect the outputs. A `cfg_commit` pulse copies the chain into the active selects, and they take effect after that clock edge.
- R9: `cfg_dout` always equals the chain MSB, so that several blocks can be daisy-chained.
- R10: Outputs follow track inputs combinationally within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Shift enable for the scan chain |
| cfg_din | input | 1 | Serial configuration data in |
| cfg_commit | input | 1 | Copies the chain into the active selects |
| cfg_dout | output | 1 | Serial data out (chain MSB) |
| trk_in_n | input | W | Tracks arriving from the north |
| trk_in_e | input | W | Tracks arriving from the east |
| trk_in_s | input | W | Tracks arriving from the south |
| trk_in_w | input | W | Tracks arriving from the west |
| trk_out_n | output | W | Tracks leaving to the north |
| trk_out_e | output | W | Tracks leaving to the east |
| trk_out_s | output | W | Tracks leaving to the south |
| trk_out_w | output | W | Tracks leaving to the west |

## Verification
The track inputs are driven with mixed per-side patterns, which separate the three source sides of a segment-end mux. A single-bit pattern on one side exposes any cross-index leak. Driving one side all ones with the others at zero shows any U-turn path. One configuration gives the same code to a segment-end field and to a mid-segment field, so a wrong stagger decision shows up as a wrong source side. Inputs are also changed between clock edges to confirm the path is combinational. A full shift before any commit, followed by idle cycles with toggling serial data, tells premature select updates apart from a chain that fails to hold.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic [1:0] {
    SIDE_N = 2'd0,
    SIDE_E = 2'd1,
    SIDE_S = 2'd2,
    SIDE_W = 2'd3
  } side_e;

  localparam int NUM_SIDES = 4;
  localparam int NUM_CAND  = NUM_SIDES - 1;

  // side reached by stepping k positions clockwise from side d
  function automatic int rot_side(input int d, input int k);
    return (d + k) % NUM_SIDES;
  endfunction

  // staggered segment boundary test
  function automatic bit seg_boundary(input int tile_x, input int trk, input int lseg);
    return ((tile_x + trk) % lseg) == 0;
  endfunction

endpackage

// File: rtl/sb_cfg_chain.sv
module sb_cfg_chain #(
  parameter int CFGW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_en,
  input  logic            cfg_din,
  input  logic            cfg_commit,
  output logic            cfg_dout,
  output logic [CFGW-1:0] active_sel,
  output logic            rst_ok
);

  logic [1:0]      rsync_q;
  logic [CFGW-1:0] chain_q, chain_d;
  logic [CFGW-1:0] shadow_q, shadow_d;

  // reset asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ok = rsync_q[1];

  always_comb begin
    chain_d  = chain_q;
    shadow_d = shadow_q;
    if (cfg_en)     chain_d  = {chain_q[CFGW-2:0], cfg_din};
    if (cfg_commit) shadow_d = chain_q;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      chain_q  <= '0;
      shadow_q <= '0;
    end else begin
      chain_q  <= chain_d;
      shadow_q <= shadow_d;
    end
  end

  assign cfg_dout   = chain_q[CFGW-1];
  assign active_sel = shadow_q;

  assert_shift_in_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    cfg_en |=> chain_q[0] == $past(cfg_din));
  assert_chain_hold_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    !cfg_en |=> $stable(chain_q));
  assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    !cfg_commit |=> $stable(shadow_q));
  assert_commit_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    cfg_commit |=> shadow_q == $past(chain_q));

endmodule

// File: rtl/sb_track_mux.sv
module sb_track_mux #(
  parameter int SELW    = 2,
  parameter bit IS_END  = 1'b1,
  parameter bit TURN_EN = 1'b1
) (
  input  logic [2:0]      cand,   // cand[k-1] = same-index track from side d+k
  input  logic [SELW-1:0] sel,
  output logic            y
);

  generate
    if (IS_END) begin : g_end
      always_comb begin
        unique case (sel)
          SELW'(1): y = cand[0];
          SELW'(2): y = cand[1];
          SELW'(3): y = cand[2];
          default:  y = 1'b0;
        endcase
      end
    end else if (TURN_EN) begin : g_turn
      logic unused_bits;
      assign unused_bits = ^{cand[2], sel[SELW-1:1]};
      assign y = sel[0] ? cand[0] : cand[1];
    end else begin : g_pass
      logic unused_bits;
      assign unused_bits = ^{cand[2], cand[0], sel};
      assign y = cand[1];
    end
  endgenerate

endmodule

// File: rtl/sb_switch_block.sv
module sb_switch_block #(
  parameter int W           = 4,
  parameter int LSEG        = 2,
  parameter int TILE_X      = 0,
  parameter bit CORNER_TURN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_en,
  input  logic         cfg_din,
  input  logic         cfg_commit,
  output logic         cfg_dout,
  input  logic [W-1:0] trk_in_n,
  input  logic [W-1:0] trk_in_e,
  input  logic [W-1:0] trk_in_s,
  input  logic [W-1:0] trk_in_w,
  output logic [W-1:0] trk_out_n,
  output logic [W-1:0] trk_out_e,
  output logic [W-1:0] trk_out_s,
  output logic [W-1:0] trk_out_w
);
  import sb_pkg::*;

  localparam int SELW  = $clog2(NUM_CAND + 1);
  localparam int NSLOT = NUM_SIDES * W;
  localparam int CFGW  = NSLOT * SELW;

  logic [NUM_SIDES-1:0][W-1:0] tin;
  logic [NUM_SIDES-1:0][W-1:0] tout;
  logic [CFGW-1:0]             active_sel;
  logic                        rst_ok;

  assign tin[SIDE_N] = trk_in_n;
  assign tin[SIDE_E] = trk_in_e;
  assign tin[SIDE_S] = trk_in_s;
  assign tin[SIDE_W] = trk_in_w;

  assign trk_out_n = tout[SIDE_N];
  assign trk_out_e = tout[SIDE_E];
  assign trk_out_s = tout[SIDE_S];
  assign trk_out_w = tout[SIDE_W];

  sb_cfg_chain #(.CFGW(CFGW)) u_chain (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_en     (cfg_en),
    .cfg_din    (cfg_din),
    .cfg_commit (cfg_commit),
    .cfg_dout   (cfg_dout),
    .active_sel (active_sel),
    .rst_ok     (rst_ok)
  );

  for (genvar d = 0; d < NUM_SIDES; d++) begin : g_side
    localparam int SRC1 = rot_side(d, 1);
    localparam int SRC2 = rot_side(d, 2);
    localparam int SRC3 = rot_side(d, 3);
    for (genvar t = 0; t < W; t++) begin : g_trk
      localparam bit IS_END = seg_boundary(TILE_X, t, LSEG);
      localparam int SLOT   = d * W + t;
      logic [2:0]      cand;
      logic [SELW-1:0] sel;

      assign cand = {tin[SRC3][t], tin[SRC2][t], tin[SRC1][t]};
      assign sel  = active_sel[SLOT*SELW +: SELW];

      sb_track_mux #(.SELW(SELW), .IS_END(IS_END), .TURN_EN(CORNER_TURN)) u_mux (
        .cand (cand),
        .sel  (sel),
        .y    (tout[d][t])
      );

      if (IS_END) begin : g_chk_end
        // with every same-index source at 0 the output must be 0 (R3, R4)
        assert_disjoint_R3: assert property (@(posedge clk) disable iff (!rst_ok)
          (tin[SRC1][t] == 1'b0 && tin[SRC2][t] == 1'b0 && tin[SRC3][t] == 1'b0)
          |-> tout[d][t] == 1'b0);
      end else begin : g_chk_mid
        assert_straight_R5: assert property (@(posedge clk) disable iff (!rst_ok)
          (!CORNER_TURN || !sel[0]) |-> tout[d][t] == tin[SRC2][t]);
        assert_turn_R5: assert property (@(posedge clk) disable iff (!rst_ok)
          (CORNER_TURN && sel[0]) |-> tout[d][t] == tin[SRC1][t]);
      end
    end
  end

endmodule

// File: tb/sb_switch_block_bench.sv
module sb_switch_block_bench;

  localparam int  CLKP   = 10;
  localparam int  W      = 4;
  localparam int  LSEG   = 2;
  localparam int  TILE_X = 0;
  localparam bit  TURN   = 1'b1;
  localparam int  SELW   = 2;
  localparam int  CFGW   = 4 * W * SELW;

  logic clk, rst_n, cfg_en, cfg_din, cfg_commit, cfg_dout;
  logic [W-1:0] in_n, in_e, in_s, in_w;
  logic [W-1:0] out_n, out_e, out_s, out_w;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [CFGW-1:0] ref_chain, ref_shadow;

  sb_switch_block #(.W(W), .LSEG(LSEG), .TILE_X(TILE_X), .CORNER_TURN(TURN)) u_sb_switch_block (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .cfg_commit(cfg_commit), .cfg_dout(cfg_dout),
    .trk_in_n(in_n), .trk_in_e(in_e), .trk_in_s(in_s), .trk_in_w(in_w),
    .trk_out_n(out_n), .trk_out_e(out_e), .trk_out_s(out_s), .trk_out_w(out_w)
  );

  initial clk = 1'b0;
  always #(CLKP/2) clk = ~clk;

  // expected outputs of side d, computed from the requirements
  function automatic logic [W-1:0] model_out(input int d, input logic [CFGW-1:0] cfg);
    logic [W-1:0] r;
    logic [W-1:0] ti [4];
    ti[0] = in_n; ti[1] = in_e; ti[2] = in_s; ti[3] = in_w;
    for (int t = 0; t < W; t++) begin
      int code;
      code = int'(cfg[(d*W+t)*SELW +: SELW]);
      if ((TILE_X + t) % LSEG == 0) begin
        r[t] = (code == 0) ? 1'b0 : ti[(d + code) % 4][t];
      end else begin
        r[t] = (TURN && (code % 2 == 1)) ? ti[(d + 1) % 4][t] : ti[(d + 2) % 4][t];
      end
    end
    return r;
  endfunction

  function automatic logic [W-1:0] side_out(input int d);
    case (d)
      0: return out_n;
      1: return out_e;
      2: return out_s;
      default: return out_w;
    endcase
  endfunction

  function automatic logic [CFGW-1:0] put_field(input logic [CFGW-1:0] c, input int d,
                                                input int t, input int code);
    logic [CFGW-1:0] r;
    r = c;
    r[(d*W+t)*SELW +: SELW] = SELW'(code);
    return r;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [W-1:0] n, e, s, w);
    in_n = n; in_e = e; in_s = s; in_w = w;
  endtask

  // drive a pattern, then compare all four sides against the model
  task automatic pattern(input string req, input logic [CFGW-1:0] cfg,
                         input logic [W-1:0] n, e, s, w);
    @(negedge clk);
    drive(n, e, s, w);
    #1;
    for (int d = 0; d < 4; d++) chk(req, side_out(d), model_out(d, cfg));
  endtask

  task automatic shift_word(input logic [CFGW-1:0] word);
    for (int i = CFGW - 1; i >= 0; i--) begin
      @(negedge clk);
      cfg_en  = 1'b1;
      cfg_din = word[i];
    end
    @(negedge clk);
    cfg_en  = 1'b0;
    cfg_din = 1'b0;
  endtask

  task automatic commit();
    @(negedge clk);
    cfg_commit = 1'b1;
    @(negedge clk);
    cfg_commit = 1'b0;
  endtask

  // cycle-by-cycle reference of the chain and the active selects
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_chain  <= '0;
      ref_shadow <= '0;
    end else begin
      if (cfg_commit) ref_shadow <= ref_chain;
      if (cfg_en)     ref_chain  <= {ref_chain[CFGW-2:0], cfg_din};
    end
  end

  always @(posedge clk) begin
    #(CLKP/4);
    if (rst_n && !done) begin
      for (int d = 0; d < 4; d++) chk("R10 per-cycle model", side_out(d), model_out(d, ref_shadow));
      chk("R9 per-cycle dout", {{(W-1){1'b0}}, cfg_dout}, {{(W-1){1'b0}}, ref_chain[CFGW-1]});
    end
  end

  initial begin
    #(CLKP * 200000);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [CFGW-1:0] cfg_a, cfg_b, cur;
    rst_n = 1'b0; cfg_en = 1'b0; cfg_din = 1'b0; cfg_commit = 1'b0;
    drive('0, '0, '0, '0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    cur = '0;
    // R1: reset state, end tracks 0, mid tracks straight
    pattern("R1 reset", cur, 4'b1010, 4'b0110, 4'b1100, 4'b0011);
    pattern("R1 reset", cur, 4'b1111, 4'b1111, 4'b1111, 4'b1111);
    chk("R1 end tracks quiet", out_n & 4'b0101, 4'b0000);

    // configuration A: mix of codes on end (0,2) and mid (1,3) tracks
    cfg_a = '0;
    cfg_a = put_field(cfg_a, 0, 0, 1); cfg_a = put_field(cfg_a, 0, 2, 3);
    cfg_a = put_field(cfg_a, 1, 0, 2); cfg_a = put_field(cfg_a, 1, 2, 1);
    cfg_a = put_field(cfg_a, 2, 0, 3); cfg_a = put_field(cfg_a, 2, 2, 0);
    cfg_a = put_field(cfg_a, 3, 0, 2); cfg_a = put_field(cfg_a, 3, 2, 1);
    cfg_a = put_field(cfg_a, 0, 1, 1); cfg_a = put_field(cfg_a, 1, 3, 3);
    cfg_a = put_field(cfg_a, 2, 1, 2); cfg_a = put_field(cfg_a, 3, 3, 2);
    shift_word(cfg_a);
    chk("R9 dout after load", {{(W-1){1'b0}}, cfg_dout}, {{(W-1){1'b0}}, cfg_a[CFGW-1]});

    // R8: shifted but not committed, outputs still follow reset selects
    pattern("R8 no commit yet", cur, 4'b1001, 4'b0101, 4'b0011, 4'b1110);

    // R7: chain holds with cfg_en low even while cfg_din toggles
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      cfg_din = ~cfg_din;
    end
    cfg_din = 1'b0;
    commit();
    cur = cfg_a;

    // R2 / R6: distinct patterns separate the three source sides
    pattern("R2 codes", cur, 4'b0101, 4'b0000, 4'b0000, 4'b0000);
    pattern("R2 codes", cur, 4'b0000, 4'b0101, 4'b0000, 4'b0000);
    pattern("R2 codes", cur, 4'b0000, 4'b0000, 4'b0101, 4'b0000);
    pattern("R2 codes", cur, 4'b0000, 4'b0000, 4'b0000, 4'b0101);
    pattern("R6 stagger", cur, 4'b1010, 4'b1110, 4'b0111, 4'b1011);
    // out_e[3] has code 3: a mid track turns from south
    @(negedge clk); drive('0, '0, 4'b1000, '0); #1;
    chk("R6 mid track code 3 turns", out_e & 4'b1000, 4'b1000);
    chk("R7 loaded field north t0 from east", out_n & 4'b0001, 4'b0000);

    // R3: a single bit on track 2 of the east side
    @(negedge clk); drive('0, 4'b0100, '0, '0); #1;
    chk("R3 disjoint north", out_n, 4'b0000);
    chk("R3 disjoint south", out_s, 4'b0000);
    chk("R3 disjoint west",  out_w, 4'b0000);
    // R4: north all ones, others zero: nothing leaves north
    @(negedge clk); drive(4'b1111, '0, '0, '0); #1;
    chk("R4 no u-turn", out_n, 4'b0000);
    // R5: mid track north t1 turns from east; south t1 goes straight
    @(negedge clk); drive('0, 4'b0010, '0, '0); #1;
    chk("R5 corner turn", out_n & 4'b0010, 4'b0010);
    chk("R5 straight not taken", out_s & 4'b0010, 4'b0000);
    // R10: change inputs between edges, no clock needed
    #1; drive(4'b0000, 4'b0001, 4'b0000, 4'b0000); #1;
    chk("R10 combinational", out_n, model_out(0, cur));
    drive(4'b0000, 4'b0000, 4'b0000, 4'b0100); #1;
    chk("R10 combinational", out_n, model_out(0, cur));

    // configuration B: end tracks code 2, mid fields code 2 (bit 1 ignored)
    cfg_b = '0;
    for (int d = 0; d < 4; d++)
      for (int t = 0; t < W; t++) cfg_b = put_field(cfg_b, d, t, 2);
    shift_word(cfg_b);
    chk("R9 dout after second load", {{(W-1){1'b0}}, cfg_dout}, {{(W-1){1'b0}}, cfg_b[CFGW-1]});
    commit();
    cur = cfg_b;
    @(negedge clk); drive(4'b1010, 4'b0110, 4'b1100, 4'b0011); #1;
    chk("R2 all straight north", out_n, 4'b1100);
    chk("R2 all straight east",  out_e, 4'b0011);
    chk("R5 mid bit1 ignored south", out_s, 4'b1010);
    chk("R2 all straight west",  out_w, 4'b0110);
    pattern("R2 code 2 model", cur, 4'b0101, 4'b1001, 4'b0110, 4'b1111);

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule